// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes stereo PCM audio from a three-wire serial link: a bit clock, a frame clock that marks which channel is being sent, and a single data line. It runs entirely on the bit clock, which serves as its clock input. On each rising edge it samples the frame clock and the data line.

A 3-bit format code selects both the word framing and the word length. The framing can be right-justified, left-justified or I2S, and the word length can be 16, 20 or 24 bits. A swap input chooses which frame-clock level means the left channel.

Each received word is placed in the upper bits of a signed 24-bit sample, with the unused low bits cleared. When a left/right pair is complete, both samples are presented together with a one-cycle valid strobe. The samples then stay unchanged until the next strobe.

Top module: `serial_audio_rx`

## Requirements
- R1: While `rst` is high, `left_out` and `right_out` are driven to zero and `valid` is low.
- R2: Every word is received most-significant bit first.
- R3: Codes 000, 001 and 010 select right-justified framing of 16, 20 and 24 bits. The word is the last N bits sampled before a frame-clock change, and it belongs to the channel of the level that is ending.
- R4: Codes 011 and 111 select left-justified framing of 24 and 20 bits. The word is the first N bits sampled from the edge on which the new frame-clock level is first seen.
- R5: Codes 100, 101 and 110 select I2S framing of 16, 24 and 20 bits. This is left-justified framing delayed by one bit-clock period: the bit sampled on the first edge of the new level is skipped.
- R6: With `lr_swap` low, a high frame clock carries the left channel. With `lr_swap` high, a low frame clock carries the left channel.
- R7: A word shorter than 24 bits fills the upper bits of its output, and the remaining lower bits are zero. Bits on the data line outside the word window have no effect on the output.
- R8: `valid` is high for exactly one cycle after the right word of a pair is complete. A right word that arrives with no left word received since the last pair is discarded and produces no strobe.
- R9: `left_out` and `right_out` change only together with a `valid` pulse.
- R10: After reset, the first frame-clock change only sets up alignment. In right-justified framing, the bits that end at that first change are never delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; all logic updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lrck | input | 1 | Frame clock selecting the channel |
| sdata | input | 1 | Serial audio data |
| fmt_code | input | 3 | Framing and word-length code |
| lr_swap | input | 1 | Frame-clock polarity select |
| left_out | output | SAMPLE_W | Left sample, left-aligned, signed |
| right_out | output | SAMPLE_W | Right sample, left-aligned, signed |
| valid | output | 1 | One-cycle strobe marking a new sample pair |

## Verification
Two situations are hard to reach from the ports: the partial half-frame before the first frame-clock change, and a right word that has no left partner. The stimulus after each reset creates both. It starts at the left level with a decoy word, then sends a lone right half, then sends the full frames. If either the decoy or the lone right word reached the outputs, it would appear as one extra strobe. The bench therefore counts strobes exactly. All eight codes are run under both polarities. Every bit outside each word window is driven to one, so a window that is misplaced by a single bit shows up in the sample value.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int WLEN_W = 5;

  typedef enum logic [1:0] {
    JUST_RIGHT = 2'd0,
    JUST_LEFT  = 2'd1,
    JUST_I2S   = 2'd2
  } just_e;

  typedef struct packed {
    just_e             just;
    logic [WLEN_W-1:0] wlen;
  } fmt_t;
endpackage

// File: rtl/srx_fmt_decode.sv
module srx_fmt_decode
  import srx_pkg::*;
(
  input  logic [2:0] code_i,
  output fmt_t       fmt_o
);
  always_comb begin
    case (code_i)
      3'b000:  fmt_o = '{just: JUST_RIGHT, wlen: WLEN_W'(16)};
      3'b001:  fmt_o = '{just: JUST_RIGHT, wlen: WLEN_W'(20)};
      3'b010:  fmt_o = '{just: JUST_RIGHT, wlen: WLEN_W'(24)};
      3'b011:  fmt_o = '{just: JUST_LEFT,  wlen: WLEN_W'(24)};
      3'b100:  fmt_o = '{just: JUST_I2S,   wlen: WLEN_W'(16)};
      3'b101:  fmt_o = '{just: JUST_I2S,   wlen: WLEN_W'(24)};
      3'b110:  fmt_o = '{just: JUST_I2S,   wlen: WLEN_W'(20)};
      default: fmt_o = '{just: JUST_LEFT,  wlen: WLEN_W'(20)};
    endcase
  end
endmodule

// File: rtl/srx_framer.sv
module srx_framer
  import srx_pkg::*;
#(
  parameter int OUT_W = 24,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lrck_i,
  input  logic             sdata_i,
  input  logic             swap_i,
  input  fmt_t             fmt_i,
  output logic             stb_o,
  output logic             stb_left_o,
  output logic [OUT_W-1:0] word_o
);
  localparam int SH_W = $clog2(OUT_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             lrck_q, primed_q, synced_q;
  logic [OUT_W-1:0] sr_q, sr_next, src, aligned;
  logic [CNT_W-1:0] pos_q, cur_k, last_k;
  logic             trans, is_rj, cap_rj, cap_lj, chan_left;

  assign trans   = primed_q && (lrck_i != lrck_q);
  assign cur_k   = trans ? '0 : pos_q;
  assign sr_next = {sr_q[OUT_W-2:0], sdata_i};
  assign is_rj   = (fmt_i.just == JUST_RIGHT);
  assign last_k  = CNT_W'(fmt_i.wlen) + CNT_W'(fmt_i.just == JUST_I2S) - CNT_W'(1);

  // right-justified: word ends just before the edge, uses the old level
  assign cap_rj    = is_rj && trans && synced_q;
  assign cap_lj    = !is_rj && (synced_q || trans) && (cur_k == last_k);
  assign src       = is_rj ? sr_q : sr_next;
  assign chan_left = is_rj ? (lrck_q ^ swap_i) : (lrck_i ^ swap_i);
  assign aligned   = src << (SH_W'(OUT_W) - SH_W'(fmt_i.wlen));

  always_ff @(posedge clk) begin
    if (rst) begin
      lrck_q     <= 1'b0;
      primed_q   <= 1'b0;
      synced_q   <= 1'b0;
      sr_q       <= '0;
      pos_q      <= '0;
      stb_o      <= 1'b0;
      stb_left_o <= 1'b0;
      word_o     <= '0;
    end else begin
      lrck_q   <= lrck_i;
      primed_q <= 1'b1;
      sr_q     <= sr_next;
      if (trans) synced_q <= 1'b1;
      pos_q    <= (cur_k == CNT_MAX) ? cur_k : cur_k + CNT_W'(1);
      stb_o    <= cap_rj || cap_lj;
      if (cap_rj || cap_lj) begin
        stb_left_o <= chan_left;
        word_o     <= aligned;
      end
    end
  end

  AST_STB_AFTER_SYNC: assert property (@(posedge clk) disable iff (rst)
    stb_o |-> synced_q);  // R10

  AST_RJ_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    (stb_o && $past(is_rj)) |-> $past(trans));  // R3
endmodule

// File: rtl/srx_pair.sv
module srx_pair #(
  parameter int OUT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb_i,
  input  logic             stb_left_i,
  input  logic [OUT_W-1:0] word_i,
  output logic [OUT_W-1:0] left_o,
  output logic [OUT_W-1:0] right_o,
  output logic             valid_o
);
  logic             have_left_q;
  logic [OUT_W-1:0] left_hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_left_q <= 1'b0;
      left_hold_q <= '0;
      left_o      <= '0;
      right_o     <= '0;
      valid_o     <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (stb_i) begin
        if (stb_left_i) begin
          left_hold_q <= word_i;
          have_left_q <= 1'b1;
        end else if (have_left_q) begin
          left_o      <= left_hold_q;
          right_o     <= word_i;
          valid_o     <= 1'b1;
          have_left_q <= 1'b0;
        end
      end
    end
  end

  AST_PAIR_EMIT: assert property (@(posedge clk) disable iff (rst)
    (stb_i && !stb_left_i && have_left_q) |=> valid_o);  // R8

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);  // R8

  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));  // R9
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import srx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = 6
) (
  input  logic                bclk,
  input  logic                rst,
  input  logic                lrck,
  input  logic                sdata,
  input  logic [2:0]          fmt_code,
  input  logic                lr_swap,
  output logic [SAMPLE_W-1:0] left_out,
  output logic [SAMPLE_W-1:0] right_out,
  output logic                valid
);
  fmt_t                fmt;
  logic                stb, stb_left;
  logic [SAMPLE_W-1:0] word;

  srx_fmt_decode u_dec (
    .code_i (fmt_code),
    .fmt_o  (fmt)
  );

  srx_framer #(.OUT_W(SAMPLE_W), .CNT_W(CNT_W)) u_framer (
    .clk        (bclk),
    .rst        (rst),
    .lrck_i     (lrck),
    .sdata_i    (sdata),
    .swap_i     (lr_swap),
    .fmt_i      (fmt),
    .stb_o      (stb),
    .stb_left_o (stb_left),
    .word_o     (word)
  );

  srx_pair #(.OUT_W(SAMPLE_W)) u_pair (
    .clk        (bclk),
    .rst        (rst),
    .stb_i      (stb),
    .stb_left_i (stb_left),
    .word_i     (word),
    .left_o     (left_out),
    .right_o    (right_out),
    .valid_o    (valid)
  );
endmodule

// File: tb/serial_audio_rx_tb.sv
module serial_audio_rx_tb_top;
  localparam int H  = 32;
  localparam int NF = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lrck = 1'b0, sdata = 1'b0, lr_swap = 1'b0;
  logic [2:0]  fmt_code = 3'd0;
  logic [23:0] left_out, right_out;
  logic        valid;

  int checks = 0, bad = 0, pairs_seen = 0, pushed = 0, stab_err = 0;
  bit done = 1'b0;
  logic [23:0] exp_l [0:127];
  logic [23:0] exp_r [0:127];
  logic [23:0] last_l = '0, last_r = '0;
  string req;

  always #5 clk = ~clk;

  serial_audio_rx dut_i (
    .bclk(clk), .rst(rst), .lrck(lrck), .sdata(sdata), .fmt_code(fmt_code),
    .lr_swap(lr_swap), .left_out(left_out), .right_out(right_out), .valid(valid)
  );

  function automatic int wlen_of(input logic [2:0] c);
    case (c)
      3'd0, 3'd4: return 16;
      3'd1, 3'd6, 3'd7: return 20;
      default: return 24;
    endcase
  endfunction

  function automatic int just_of(input logic [2:0] c);  // 0 right, 1 left, 2 I2S
    if (c <= 3'd2) return 0;
    if (c == 3'd3 || c == 3'd7) return 1;
    return 2;
  endfunction

  // bits outside the word window are driven high
  task automatic drive_half(input logic lvl, input logic [23:0] w, input int wl, input int j);
    for (int k = 0; k < H; k++) begin
      logic b;
      b = 1'b1;
      if (j == 0 && k >= H - wl) b = w[H-1-k];
      else if (j == 1 && k < wl) b = w[wl-1-k];
      else if (j == 2 && k >= 1 && k <= wl) b = w[wl-k];
      @(negedge clk);
      lrck  = lvl;
      sdata = b;
    end
  endtask

  always @(negedge clk) begin
    if (rst) begin
      last_l <= '0;
      last_r <= '0;
    end else if (valid) begin
      checks++;
      if (pairs_seen >= pushed) begin
        bad++;
        $display("FAIL R8 R10 unexpected pair: got %h/%h expected no strobe", left_out, right_out);
      end else if (left_out !== exp_l[pairs_seen] || right_out !== exp_r[pairs_seen]) begin
        bad++;
        $display("FAIL %s R2 R6 R7 pair %0d: got %h/%h expected %h/%h", req, pairs_seen,
                 left_out, right_out, exp_l[pairs_seen], exp_r[pairs_seen]);
      end
      pairs_seen++;
      last_l <= left_out;
      last_r <= right_out;
    end else if (left_out !== last_l || right_out !== last_r) begin
      stab_err++;
    end
  end

  initial begin
    for (int f = 0; f < 8; f++) begin
      for (int p = 0; p < 2; p++) begin
        int wl, j, base_pairs, base_stab;
        logic lvl_l;
        logic [23:0] mask, wlw, wrw;
        wl    = wlen_of(3'(f));
        j     = just_of(3'(f));
        req   = (j == 0) ? "R3" : (j == 1) ? "R4" : "R5";
        mask  = 24'((1 << wl) - 1);
        lvl_l = (p == 0);  // R6: swap low -> high level is left
        rst = 1'b1; fmt_code = 3'(f); lr_swap = 1'(p); lrck = lvl_l; sdata = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (left_out !== '0 || right_out !== '0 || valid !== 1'b0) begin
          bad++;
          $display("FAIL R1 reset: got %h/%h/%b expected 0/0/0", left_out, right_out, valid);
        end
        base_pairs = pairs_seen;
        base_stab  = stab_err;
        rst = 1'b0;
        drive_half(lvl_l, 24'h5A5A5A & mask, wl, j);   // R10 decoy before alignment
        drive_half(!lvl_l, 24'h3C3C3C & mask, wl, j);  // R8 lone right word
        for (int n = 0; n < NF; n++) begin
          if (n == 0) begin
            wlw = 24'(1) << (wl - 1);  // MSB only
            wrw = 24'h000001;          // LSB only
          end else begin
            wlw = 24'($urandom) & mask;
            wrw = 24'($urandom) & mask;
          end
          exp_l[pushed] = wlw << (24 - wl);
          exp_r[pushed] = wrw << (24 - wl);
          pushed++;
          drive_half(lvl_l, wlw, wl, j);
          drive_half(!lvl_l, wrw, wl, j);
        end
        drive_half(lvl_l, 24'h0, wl, j);
        repeat (4) @(negedge clk);
        checks++;
        if (pairs_seen - base_pairs != NF) begin
          bad++;
          $display("FAIL R8 R10 strobe count code %0d: got %0d expected %0d", f,
                   pairs_seen - base_pairs, NF);
        end
        checks++;
        if (stab_err != base_stab) begin
          bad++;
          $display("FAIL R9 outputs moved without strobe: got %0d changes expected 0",
                   stab_err - base_stab);
        end
      end
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule